// File: doc/BRIEF.md
# Register List Stack Sequencer

This block moves a chosen subset of up to sixteen general registers between a register file and a full-descending stack in memory. A caller gives it a 16-bit selection mask, a direction and the current stack pointer, then pulses start. The block moves one 32-bit word per accepted memory cycle and hands the final stack pointer back when it finishes.

A push visits the selected registers from the lowest index to the highest. For each one it lowers the stack pointer by four and stores the register at the new address. A pop visits them from the highest index to the lowest. For each one it loads the word at the stack pointer into the register and then raises the pointer by four. Because the two scan orders mirror each other, a pop with the same mask puts every value back in the register it came from.

The memory side is a single-port request interface. The request is held until `mem_ready_i` is high. In that same cycle a write is taken and read data is valid. Register reads are combinational: the index goes out and the value comes back in the same cycle.

Top module: `regstack_seq`

## Requirements
- R1: Push (`dir_pop_i`=0) handles selected registers in ascending index order. Register i is written to address SP0 − 4·k, where k counts the set mask bits at indices ≤ i.
- R2: Pop (`dir_pop_i`=1) handles selected registers in descending index order. Register i is loaded from SP0 + 4·j, where j counts the set mask bits at indices > i. Consecutive accepted pop reads step the address up by 4, and consecutive push writes step it down by 4.
- R3: A register whose mask bit is 0 causes no memory access and is not written. The number of accepted memory cycles equals the number of set mask bits.
- R4: On completion `sp_we_o` is high for exactly the `done_o` cycle. `sp_wdata_o` carries SP0 − 4·n after a push and SP0 + 4·n after a pop, where n is the number of set mask bits.
- R5: An all-zero mask raises `done_o` in the first cycle after start is sampled. It makes no memory request and returns SP0 unchanged.
- R6: While `mem_req_o` is high and `mem_ready_i` is low, the request, the address, the write flag and the write data hold their values into the next cycle.
- R7: `done_o` is a single-cycle pulse. `busy_o` rises in the cycle after an accepted start and stays high through the `done_o` cycle. `busy_o` stays low unless start was sampled.
- R8: Start is accepted only when `busy_o` is low. A start, mask or direction presented while busy has no effect on the transfer or on the final SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| dir_pop_i | input | 1 | 0 = push, 1 = pop |
| mask_i | input | 16 | Register selection mask |
| sp_i | input | 32 | Stack pointer at start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_idx_o | output | 4 | Register index for the current word |
| rf_rd_en_o | output | 1 | Register read active (push) |
| rf_rdata_i | input | 32 | Register read data |
| rf_we_o | output | 1 | Register write strobe (pop) |
| rf_wdata_o | output | 32 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (push) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the access |
| sp_we_o | output | 1 | Final stack pointer write strobe |
| sp_wdata_o | output | 32 | Final stack pointer value |

## Verification
The bench sweeps every single-bit mask, the empty and full masks, alternating and end-only patterns, and a spread of pseudo-random masks. Each mask is run with memory always ready and with random stalls. Every push is followed by garbage written into the registers and then a pop with the same mask.

- Getting the scan order or the decrement-before-store ordering wrong places words at shifted addresses. The pop then restores values into the wrong registers.
- Letting a cleared bit leak through produces an extra access and an off-by-four stack pointer.
- Treating the empty mask as a normal transfer either hangs the block or issues a request.
- Advancing during a stall moves the address while the memory still holds the old request.
- Starts presented during a transfer would retarget it mid-flight if they were not ignored.

// File: rtl/regstack_seq.sv
module regstack_seq #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    dir_pop_i,
  input  logic [NREG-1:0]         mask_i,
  input  logic [AW-1:0]           sp_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [$clog2(NREG)-1:0] rf_idx_o,
  output logic                    rf_rd_en_o,
  input  logic [DW-1:0]           rf_rdata_i,
  output logic                    rf_we_o,
  output logic [DW-1:0]           rf_wdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [DW-1:0]           mem_wdata_o,
  input  logic [DW-1:0]           mem_rdata_i,
  input  logic                    mem_ready_i,
  output logic                    sp_we_o,
  output logic [AW-1:0]           sp_wdata_o
);
  localparam int IW = $clog2(NREG);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t          state;
  logic [NREG-1:0] pend;
  logic            pop_r;
  logic [AW-1:0]   sp_r;
  logic [IW-1:0]   lo_idx, hi_idx, cur;
  logic [NREG-1:0] pend_nx;
  logic            run, step;

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = NREG-1; i >= 0; i--)
      if (pend[i]) lo_idx = IW'(i);
    for (int i = 0; i < NREG; i++)
      if (pend[i]) hi_idx = IW'(i);
  end

  assign cur     = pop_r ? hi_idx : lo_idx;
  assign pend_nx = pend & ~(NREG'(1) << cur);
  assign run     = (state == S_RUN);
  assign step    = run && mem_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pend  <= '0;
      pop_r <= 1'b0;
      sp_r  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          pend  <= mask_i;
          pop_r <= dir_pop_i;
          sp_r  <= sp_i;
          state <= (mask_i == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (step) begin
          pend  <= pend_nx;
          sp_r  <= pop_r ? sp_r + AW'(STEP) : sp_r - AW'(STEP);
          if (pend_nx == '0) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state != S_IDLE);
  assign done_o      = (state == S_FIN);
  assign rf_idx_o    = cur;
  assign rf_rd_en_o  = run && !pop_r;
  assign rf_we_o     = step && pop_r;
  assign rf_wdata_o  = mem_rdata_i;
  assign mem_req_o   = run;
  assign mem_we_o    = run && !pop_r;
  assign mem_addr_o  = pop_r ? sp_r : sp_r - AW'(STEP);
  assign mem_wdata_o = rf_rdata_i;
  assign sp_we_o     = done_o;
  assign sp_wdata_o  = sp_r;
endmodule

module regstack_seq_chk #(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          rf_we_o
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o ||
      mem_addr_o == ($past(mem_we_o) ? $past(mem_addr_o) - AW'(STEP)
                                     : $past(mem_addr_o) + AW'(STEP))));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

  assert_rf_write_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);
endmodule

bind regstack_seq regstack_seq_chk #(.DW(DW), .AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .rf_we_o(rf_we_o)
);

// File: tb/test_regstack_seq.sv
`timescale 1ns/1ps
module test_regstack_seq;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SP0  = BASE + 32'd192;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start_i = 0, dir_pop_i = 0, mem_ready_i = 1;
  logic [15:0] mask_i = '0;
  logic        busy_o, done_o, rf_rd_en_o, rf_we_o, mem_req_o, mem_we_o, sp_we_o;
  logic [3:0]  rf_idx_o;
  logic [31:0] rf_rdata_i, rf_wdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i, sp_wdata_o;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];
  logic [31:0] sp_q;
  logic        ld_en = 0;
  logic [31:0] ld_regs [16];
  logic [31:0] ld_sp = '0;
  int          acc_cnt = 0;
  logic        acc_clr = 0;

  function automatic int widx(input logic [31:0] a);
    logic [31:0] d;
    d = (a - BASE) >> 2;
    return int'(d[5:0]);
  endfunction

  assign rf_rdata_i  = regs[rf_idx_o];
  assign mem_rdata_i = mem[widx(mem_addr_o)];

  always @(posedge clk) begin
    if (ld_en) begin
      for (int i = 0; i < 16; i++) regs[i] <= ld_regs[i];
      sp_q <= ld_sp;
    end else begin
      if (rf_we_o) regs[rf_idx_o] <= rf_wdata_o;
      if (sp_we_o) sp_q <= sp_wdata_o;
    end
    if (mem_req_o && mem_ready_i && mem_we_o) mem[widx(mem_addr_o)] <= mem_wdata_o;
    if (acc_clr) acc_cnt <= 0;
    else if (mem_req_o && mem_ready_i) acc_cnt <= acc_cnt + 1;
  end

  regstack_seq i_regstack_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_pop_i(dir_pop_i), .mask_i(mask_i),
    .sp_i(sp_q), .busy_o(busy_o), .done_o(done_o), .rf_idx_o(rf_idx_o),
    .rf_rd_en_o(rf_rd_en_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_wdata_o(rf_wdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ready_i(mem_ready_i), .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o)
  );

  int nchk = 0, nfail = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic stall_mode = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] seed, input logic [31:0] sp);
    @(negedge clk);
    for (int i = 0; i < 16; i++) ld_regs[i] = seed ^ (32'h0101_0101 * (i + 1));
    ld_sp = sp;
    ld_en = 1;
    acc_clr = 1;
    @(negedge clk);
    ld_en = 0;
    acc_clr = 0;
  endtask

  task automatic run_op(input logic pop, input logic [15:0] m);
    logic        hold_ok;
    logic        prev_stall;
    logic [31:0] prev_addr;
    int          cyc;
    hold_ok = 1;
    prev_stall = 0;
    prev_addr = '0;
    cyc = 0;
    mem_ready_i = 1;
    dir_pop_i = pop;
    mask_i = m;
    start_i = 1;
    @(negedge clk);
    dir_pop_i = ~pop;
    mask_i = ~m;
    chk(busy_o === 1'b1, "R7 busy after start", 32'(busy_o), 32'd1);
    if (m == '0) begin
      chk(done_o === 1'b1, "R5 empty mask done next cycle", 32'(done_o), 32'd1);
      chk(mem_req_o === 1'b0, "R5 empty mask no request", 32'(mem_req_o), 32'd0);
    end
    while (!done_o && cyc < 2000) begin
      if (prev_stall && mem_addr_o !== prev_addr) hold_ok = 0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready_i = stall_mode ? lfsr[0] | lfsr[3] : 1'b1;
      prev_stall = mem_req_o && !mem_ready_i;
      prev_addr = mem_addr_o;
      @(negedge clk);
      cyc++;
    end
    chk(hold_ok, "R6 address held during stall", 32'(hold_ok), 32'd1);
    chk(done_o === 1'b1 && sp_we_o === 1'b1, "R4 sp write with done",
        {done_o, sp_we_o}, 32'd3);
    start_i = 0;
    mem_ready_i = 1;
    @(negedge clk);
    chk(done_o === 1'b0, "R7 done one cycle", 32'(done_o), 32'd0);
  endtask

  task automatic full_case(input logic [15:0] m, input logic [31:0] seed);
    logic [31:0] orig [16];
    logic [31:0] junk [16];
    int          k, n;
    bit          ok;
    n = $countones(m);
    load(seed, SP0);
    for (int i = 0; i < 16; i++) orig[i] = ld_regs[i];
    run_op(1'b0, m);
    chk(acc_cnt == n, "R3 push access count", 32'(acc_cnt), 32'(n));
    chk(sp_q == SP0 - 32'(4*n), "R4 push final sp", sp_q, SP0 - 32'(4*n));
    ok = 1;
    k = 0;
    for (int i = 0; i < 16; i++)
      if (m[i]) begin
        k++;
        if (mem[widx(SP0 - 32'(4*k))] !== orig[i]) ok = 0;
      end
    chk(ok, "R1 push placement", 32'(m), 32'(m));
    load(~seed, SP0 - 32'(4*n));
    for (int i = 0; i < 16; i++) junk[i] = ld_regs[i];
    run_op(1'b1, m);
    chk(acc_cnt == n, "R3 pop access count", 32'(acc_cnt), 32'(n));
    chk(sp_q == SP0, "R4 pop final sp", sp_q, SP0);
    ok = 1;
    for (int i = 0; i < 16; i++)
      if (m[i] ? (regs[i] !== orig[i]) : (regs[i] !== junk[i])) ok = 0;
    chk(ok, "R2 R3 R8 pop restore and skip", 32'(m), 32'(m));
  endtask

  bit finished = 0;
  initial begin
    #(200000 * 4);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) ld_regs[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && mem_req_o === 1'b0, "R7 reset idle",
        {busy_o, done_o, mem_req_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      stall_mode = s[0];
      load(32'h1234_0000, SP0);
      run_op(1'b0, 16'h0000);
      chk(acc_cnt == 0 && sp_q == SP0, "R5 empty mask sp unchanged", sp_q, SP0);
      for (int b = 0; b < 16; b++) full_case(16'(1) << b, 32'hB000_0000 + 32'(b));
      full_case(16'hFFFF, 32'h5A5A_0001);
      full_case(16'hAAAA, 32'h5A5A_0002);
      full_case(16'h5555, 32'h5A5A_0003);
      full_case(16'h8001, 32'h5A5A_0004);
      for (int r = 0; r < 24; r++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        full_case(lfsr ^ 16'(r * 40503), 32'hC0DE_0000 + 32'(r));
      end
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule